// File: doc/BRIEF.md
# Host Bridge Address Decoder

This block sits between a processor bus and the rest of a host bridge and decides, for every access, which target receives it. It selects one of DRAM, a boot ROM window, PCI I/O space, PCI memory space, an interrupt-acknowledge cell, the bridge's own PCI configuration index register, the configuration data port, or an unassigned sink. It also hands the selected target the address translated into that target's local space. The decode is purely combinational from the request to the target select, the translated address, the write strobe and the read-data mux. The only state is the configuration index register.

DRAM is reached through a set of banks. Each bank has an enable bit and a base and limit given in 1 MB units on input ports, so the memory-controller setup lives outside this block. A small combinational function folds a PCI device's interrupt pin onto one of two interrupt outputs.

Top module: `host_addr_map`

## Requirements
- R1: After reset the configuration index register `cfg_addr` reads 0.
- R2: Addresses 0xFFF00000 to 0xFFFFFFFF select the boot ROM (`tgt_sel`=2), with `tgt_addr` equal to the offset within that 1 MB and read data taken from `rom_rdata`. A write there never raises `tgt_wr`.
- R3: Addresses 0xBFFFFFF0 to 0xBFFFFFFF select interrupt acknowledge (`tgt_sel`=5) only for single-byte accesses (`req_bytes`=1). `tgt_addr` is the offset within the 16 bytes, and a read returns `intack_vec` zero-extended. A wider access there is unassigned, and no access there raises `tgt_wr`.
- R4: Addresses 0xC0000000 to 0xFEFFFFFF select PCI memory (`tgt_sel`=4), with `tgt_addr` = address − 0xC0000000 and read data from `pci_rdata`.
- R5: Addresses 0x80000000 to 0xBF7FFFFF select PCI I/O (`tgt_sel`=3), with `tgt_addr` = address − 0x80000000 and read data from `pci_rdata`. Offsets 0xCF8 to 0xCFF are the exceptions covered by R6 and R7.
- R6: I/O offsets 0xCF8 to 0xCFB select the configuration index register (`tgt_sel`=6, `tgt_addr` = address bits 1:0). The access is little-endian: request byte i (`req_wdata[8i+7:8i]`) goes to register byte (address[1:0]+i) for i < `req_bytes`, and bytes beyond 3 are dropped. A read returns the register shifted right by 8×address[1:0]. The register changes on no other access.
- R7: I/O offsets 0xCFC to 0xCFF select the configuration data port (`tgt_sel`=7). `tgt_addr` is {`cfg_addr`[31:2], address[1:0]}, writes are forwarded and reads come from `pci_rdata`.
- R8: An address that no higher target claims selects DRAM (`tgt_sel`=1) when an enabled bank satisfies base ≤ address[31:20] ≤ limit. The lowest-numbered such bank wins and is reported on `tgt_bank`. `tgt_addr` = address − base×2^20, and read data comes from `dram_rdata`.
- R9: An address that no target claims is unassigned (`tgt_sel`=0), with `tgt_addr` 0, `tgt_wr` low and read data 0.
- R10: Decode priority runs boot ROM, interrupt acknowledge, PCI memory, PCI I/O (configuration ports included), DRAM bank, unassigned. A bank placed over a bridge window never takes an access from it.
- R11: `irq_out` equals (`irq_pin` + `irq_dev`) mod 2.
- R12: With `req_valid` low the select is 0 and `tgt_wr` is low. `tgt_wr` rises only for valid writes to targets 1, 3, 4 or 7. `rsp_rdata` is 0 for writes and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bytes | input | 3 | Access size in bytes (1, 2 or 4) |
| req_addr | input | 32 | Processor bus address |
| req_wdata | input | 32 | Write data, byte i in bits 8i+7:8i |
| bank_base | input | NUM_BANKS*12 | Per-bank first MB |
| bank_limit | input | NUM_BANKS*12 | Per-bank last MB |
| bank_enable | input | NUM_BANKS | Per-bank enable |
| intack_vec | input | 8 | Pending interrupt vector |
| dram_rdata | input | 32 | DRAM read data |
| rom_rdata | input | 32 | Boot ROM read data |
| pci_rdata | input | 32 | PCI read data |
| tgt_sel | output | 3 | Selected target code |
| tgt_addr | output | 32 | Translated target address |
| tgt_bank | output | BANK_W | DRAM bank index |
| tgt_wr | output | 1 | Write strobe to the target |
| rsp_rdata | output | 32 | Read data to the processor |
| cfg_addr | output | 32 | Configuration index register |
| irq_pin | input | 2 | PCI interrupt pin (0 to 3) |
| irq_dev | input | 5 | PCI device number |
| irq_out | output | 1 | Selected interrupt output |

## Verification
On every cycle, the assertions check several properties. ROM and interrupt-acknowledge selections carry no write strobe, and interrupt acknowledge is only ever chosen for single-byte accesses. The unassigned sink stays silent, and an idle bus selects nothing. Translated I/O and memory offsets stay inside their window sizes, a DRAM hit always names an enabled bank, and the configuration index holds whenever it is not written. Other behaviour is shown only by the bench's sweeps across every window edge, overlapping and misordered bank setups, and banks laid over bridge windows. These cover the exact translated values, the priority of one target over another, the lowest-bank rule, the little-endian lane placement in the index register, and the interrupt fold.

// File: rtl/host_addr_map.sv
module host_addr_map #(
  parameter int NUM_BANKS = 4,
  parameter int VEC_W = 8,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int MB_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [2:0]                req_bytes,
  input  logic [31:0]               req_addr,
  input  logic [31:0]               req_wdata,
  input  logic [NUM_BANKS*MB_W-1:0] bank_base,
  input  logic [NUM_BANKS*MB_W-1:0] bank_limit,
  input  logic [NUM_BANKS-1:0]      bank_enable,
  input  logic [VEC_W-1:0]          intack_vec,
  input  logic [31:0]               dram_rdata,
  input  logic [31:0]               rom_rdata,
  input  logic [31:0]               pci_rdata,
  output logic [2:0]                tgt_sel,
  output logic [31:0]               tgt_addr,
  output logic [BANK_W-1:0]         tgt_bank,
  output logic                      tgt_wr,
  output logic [31:0]               rsp_rdata,
  output logic [31:0]               cfg_addr,
  input  logic [1:0]                irq_pin,
  input  logic [4:0]                irq_dev,
  output logic                      irq_out
);
  localparam logic [2:0] T_NONE = 3'd0, T_DRAM = 3'd1, T_ROM = 3'd2, T_IO = 3'd3,
                         T_MEM = 3'd4, T_ACK = 3'd5, T_CFGI = 3'd6, T_CFGD = 3'd7;
  localparam logic [31:0] IO_BASE = 32'h8000_0000, MEM_BASE = 32'hC000_0000;
  localparam logic [31:0] IO_SIZE = 32'h3F80_0000, MEM_SIZE = 32'h3F00_0000;

  logic [MB_W-1:0] mb;
  logic [31:0] io_off, mem_off;
  logic hit_rom, hit_ack, hit_mem, hit_io;

  assign mb      = req_addr[31:20];
  assign io_off  = req_addr - IO_BASE;
  assign mem_off = req_addr - MEM_BASE;
  assign hit_rom = mb == 12'hFFF;
  assign hit_ack = req_addr[31:4] == 28'hBFF_FFFF;
  assign hit_mem = req_addr[31:30] == 2'b11 && req_addr[31:24] != 8'hFF;
  assign hit_io  = req_addr[31:30] == 2'b10 && req_addr[31:23] != 9'b1011_1111_1;

  logic bank_hit;
  logic [BANK_W-1:0] bank_idx;
  logic [MB_W-1:0] bank_sel_base;

  always_comb begin
    bank_hit = 1'b0;
    bank_idx = '0;
    bank_sel_base = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (bank_enable[i] && bank_base[i*MB_W +: MB_W] <= mb && mb <= bank_limit[i*MB_W +: MB_W]) begin
        bank_hit = 1'b1;
        bank_idx = i[BANK_W-1:0];
        bank_sel_base = bank_base[i*MB_W +: MB_W];
      end
    end
  end

  always_comb begin
    tgt_sel = T_NONE;
    tgt_addr = '0;
    tgt_bank = '0;
    if (!req_valid) begin
      tgt_sel = T_NONE;
    end else if (hit_rom) begin
      tgt_sel = T_ROM;
      tgt_addr = {12'h000, req_addr[19:0]};
    end else if (hit_ack) begin
      if (req_bytes == 3'd1) begin
        tgt_sel = T_ACK;
        tgt_addr = {28'h0, req_addr[3:0]};
      end
    end else if (hit_mem) begin
      tgt_sel = T_MEM;
      tgt_addr = mem_off;
    end else if (hit_io) begin
      if (io_off[31:2] == 30'h33E) begin
        tgt_sel = T_CFGI;
        tgt_addr = {30'h0, req_addr[1:0]};
      end else if (io_off[31:2] == 30'h33F) begin
        tgt_sel = T_CFGD;
        tgt_addr = {cfg_addr[31:2], req_addr[1:0]};
      end else begin
        tgt_sel = T_IO;
        tgt_addr = io_off;
      end
    end else if (bank_hit) begin
      tgt_sel = T_DRAM;
      tgt_addr = req_addr - {bank_sel_base, 20'h0};
      tgt_bank = bank_idx;
    end
  end

  assign tgt_wr = req_valid && req_write &&
                  (tgt_sel == T_DRAM || tgt_sel == T_IO || tgt_sel == T_MEM || tgt_sel == T_CFGD);

  always_comb begin
    rsp_rdata = '0;
    if (req_valid && !req_write) begin
      case (tgt_sel)
        T_DRAM: rsp_rdata = dram_rdata;
        T_ROM:  rsp_rdata = rom_rdata;
        T_IO, T_MEM, T_CFGD: rsp_rdata = pci_rdata;
        T_ACK:  rsp_rdata = {{(32-VEC_W){1'b0}}, intack_vec};
        T_CFGI: rsp_rdata = cfg_addr >> {req_addr[1:0], 3'b000};
        default: rsp_rdata = '0;
      endcase
    end
  end

  logic cfg_we;
  logic [7:0] lane_mask;
  logic [31:0] wsh;
  assign cfg_we = req_valid && req_write && tgt_sel == T_CFGI;
  assign lane_mask = ((8'd1 << req_bytes) - 8'd1) << req_addr[1:0];
  assign wsh = req_wdata << {req_addr[1:0], 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_addr <= '0;
    end else if (cfg_we) begin
      for (int j = 0; j < 4; j++) begin
        if (lane_mask[j]) cfg_addr[8*j +: 8] <= wsh[8*j +: 8];
      end
    end
  end

  logic [5:0] irq_sum;
  assign irq_sum = {4'b0, irq_pin} + {1'b0, irq_dev};
  assign irq_out = irq_sum[0];

  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel == T_ROM |-> !tgt_wr); // R2
  AST_ACK_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel == T_ACK |-> req_bytes == 3'd1 && !tgt_wr); // R3
  AST_MEM_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel == T_MEM |-> tgt_addr < MEM_SIZE); // R4
  AST_IO_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel == T_IO |-> tgt_addr < IO_SIZE); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_addr)); // R6
  AST_BANK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel == T_DRAM |-> bank_enable[tgt_bank]); // R8
  AST_SINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel == T_NONE |-> rsp_rdata == 32'h0 && !tgt_wr && tgt_addr == 32'h0); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> tgt_sel == T_NONE && !tgt_wr && rsp_rdata == 32'h0); // R12
endmodule

// File: tb/tb_host_addr_map.sv
module tb_host_addr_map;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_bytes = 3'd1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [47:0] bank_base = '0, bank_limit = '0;
  logic [3:0] bank_enable = '0;
  logic [7:0] intack_vec = 8'h5A;
  logic [31:0] dram_rdata = 32'h1111_1111, rom_rdata = 32'h2222_2222, pci_rdata = 32'h3333_3333;
  logic [2:0] tgt_sel;
  logic [31:0] tgt_addr, rsp_rdata, cfg_addr;
  logic [1:0] tgt_bank, irq_pin = '0;
  logic [4:0] irq_dev = '0;
  logic tgt_wr, irq_out;

  int total = 0, bad = 0;
  logic [31:0] m_cfg = '0;

  host_addr_map dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bytes(req_bytes), .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_base(bank_base), .bank_limit(bank_limit), .bank_enable(bank_enable),
    .intack_vec(intack_vec), .dram_rdata(dram_rdata), .rom_rdata(rom_rdata),
    .pci_rdata(pci_rdata), .tgt_sel(tgt_sel), .tgt_addr(tgt_addr), .tgt_bank(tgt_bank),
    .tgt_wr(tgt_wr), .rsp_rdata(rsp_rdata), .cfg_addr(cfg_addr),
    .irq_pin(irq_pin), .irq_dev(irq_dev), .irq_out(irq_out));

  always #10 clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [2:0] s);
    case (s)
      3'd1: return "R8"; 3'd2: return "R2"; 3'd3: return "R5"; 3'd4: return "R4";
      3'd5: return "R3"; 3'd6: return "R6"; 3'd7: return "R7"; default: return "R9";
    endcase
  endfunction

  function automatic void model(input logic [31:0] a, input logic [2:0] nb,
                                output logic [2:0] s, output logic [31:0] ta, output logic [1:0] bk);
    logic found;
    logic [31:0] off;
    s = 3'd0; ta = '0; bk = '0; found = 1'b0;
    if (a >= 32'hFFF0_0000) begin
      s = 3'd2; ta = a - 32'hFFF0_0000;
    end else if (a >= 32'hBFFF_FFF0 && a <= 32'hBFFF_FFFF) begin
      if (nb == 3'd1) begin s = 3'd5; ta = a - 32'hBFFF_FFF0; end
    end else if (a >= 32'hC000_0000 && a < 32'hFF00_0000) begin
      s = 3'd4; ta = a - 32'hC000_0000;
    end else if (a >= 32'h8000_0000 && a < 32'hBF80_0000) begin
      off = a - 32'h8000_0000;
      if (off >= 32'hCF8 && off < 32'hCFC) begin s = 3'd6; ta = off - 32'hCF8; end
      else if (off >= 32'hCFC && off < 32'hD00) begin s = 3'd7; ta = (m_cfg & ~32'h3) | (off - 32'hCFC); end
      else begin s = 3'd3; ta = off; end
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (!found && bank_enable[i] && {20'h0, bank_base[i*12 +: 12]} <= (a >> 20)
            && (a >> 20) <= {20'h0, bank_limit[i*12 +: 12]}) begin
          found = 1'b1; s = 3'd1; bk = i[1:0];
          ta = a - {bank_base[i*12 +: 12], 20'h0};
        end
      end
    end
  endfunction

  task automatic acc(logic [31:0] a, logic w, logic [2:0] nb, logic [31:0] wd, string tag_in);
    logic [2:0] es; logic [31:0] ea, ed; logic [1:0] eb; string t;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bytes = nb; req_addr = a; req_wdata = wd;
    #2;
    model(a, nb, es, ea, eb);
    t = (tag_in == "") ? tag_of(es) : tag_in;
    ed = '0;
    if (!w) case (es)
      3'd1: ed = dram_rdata; 3'd2: ed = rom_rdata; 3'd3, 3'd4, 3'd7: ed = pci_rdata;
      3'd5: ed = {24'h0, intack_vec}; 3'd6: ed = m_cfg >> (8 * a[1:0]); default: ed = '0;
    endcase
    chk(t, "tgt_sel", {29'h0, tgt_sel}, {29'h0, es});
    chk(t, "tgt_addr", tgt_addr, ea);
    chk(t, "tgt_bank", {30'h0, tgt_bank}, {30'h0, eb});
    chk(t, "tgt_wr", {31'h0, tgt_wr}, {31'h0, w && (es == 3'd1 || es == 3'd3 || es == 3'd4 || es == 3'd7)});
    chk(t, "rsp_rdata", rsp_rdata, ed);
    if (w && es == 3'd6)
      for (int i = 0; i < 4; i++)
        if (i < nb && a[1:0] + i < 4) m_cfg[8*(a[1:0]+i) +: 8] = wd[8*i +: 8];
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk("R6", "cfg_addr", cfg_addr, m_cfg);
  endtask

  task automatic sweep(string tag);
    logic [31:0] edges [0:19];
    edges = '{32'h7FFF_FFFF, 32'h8000_0000, 32'hBF7F_FFFF, 32'hBF80_0000, 32'hBFFF_FFEF,
              32'hBFFF_FFF0, 32'hBFFF_FFF7, 32'hBFFF_FFFF, 32'hC000_0000, 32'hFEFF_FFFF,
              32'hFF00_0000, 32'hFFEF_FFFF, 32'hFFF0_0000, 32'hFFFF_FFFF, 32'h8000_0CF4,
              32'h8000_0CFC, 32'h8000_0CFF, 32'h8000_0D00, 32'hBF90_0004, 32'hBF8F_FFFF};
    for (int k = 0; k < 256; k++) begin
      acc({k[7:0], 24'h0}, 1'b0, 3'd4, 32'h0, tag);
      acc({k[7:0], 24'hFFFFFC}, 1'b1, 3'd4, 32'hA5A5_0000 | k, tag);
    end
    for (int e = 0; e < 20; e++) begin
      acc(edges[e], 1'b0, 3'd1, 32'h0, tag);
      acc(edges[e], 1'b0, 3'd4, 32'h0, tag);
      acc(edges[e], 1'b1, 3'd1, 32'h77, tag);
      acc(edges[e], 1'b1, 3'd2, 32'h7788, tag);
    end
  endtask

  initial begin
    #5_000_000;
    bad++;
    $display("FAIL watchdog expired before completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "cfg_addr after reset", cfg_addr, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R12", "idle tgt_sel", {29'h0, tgt_sel}, 32'h0);
    chk("R12", "idle tgt_wr", {31'h0, tgt_wr}, 32'h0);
    chk("R12", "idle rsp_rdata", rsp_rdata, 32'h0);

    // banks: b1 overlaps b2 (lowest wins), b3 misordered never hits
    bank_base  = {12'h080, 12'h020, 12'h010, 12'h000};
    bank_limit = {12'h07F, 12'h03F, 12'h02F, 12'h00F};
    bank_enable = 4'b1111;
    sweep("");
    acc(32'h0250_0000, 1'b0, 3'd4, 32'h0, "R8");
    acc(32'h0350_0000, 1'b0, 3'd4, 32'h0, "R8");

    // index register lanes
    acc(32'h8000_0CF8, 1'b1, 3'd4, 32'h8000_1234, "R6");
    acc(32'h8000_0CF8, 1'b0, 3'd4, 32'h0, "R6");
    acc(32'h8000_0CFA, 1'b1, 3'd1, 32'h0000_00AB, "R6");
    acc(32'h8000_0CF9, 1'b1, 3'd2, 32'h0000_CDEF, "R6");
    acc(32'h8000_0CFB, 1'b0, 3'd1, 32'h0, "R6");
    acc(32'h8000_0CFB, 1'b1, 3'd4, 32'h1122_3344, "R6");
    acc(32'h8000_0CFE, 1'b0, 3'd2, 32'h0, "R7");
    acc(32'h8000_0CFD, 1'b1, 3'd1, 32'h0, "R7");
    acc(32'hBFFF_FFF3, 1'b0, 3'd2, 32'h0, "R3");

    // second set: bank in the I/O gap, disabled bank 0, banks over bridge windows
    bank_base  = {12'hBF9, 12'hC00, 12'h800, 12'h000};
    bank_limit = {12'hBF9, 12'hC0F, 12'hFFF, 12'h0FF};
    bank_enable = 4'b1110;
    sweep("R10");

    for (int p = 0; p < 4; p++)
      for (int d = 0; d < 32; d++) begin
        irq_pin = p[1:0]; irq_dev = d[4:0];
        #1;
        chk("R11", "irq_out", {31'h0, irq_out}, {31'h0, ((p + d) % 2 == 1)});
      end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule